// File: doc/BRIEF.md
# Slave Configuration Stream Loader

This block takes in a configuration image as a slave of an external configuration clock and stores it in a local register of fixed length. It has two input modes. In serial mode it takes one bit per rising clock edge from a single data pin. In parallel mode it takes a whole byte per rising edge from an 8-bit bus, but only on edges where two chip selects of opposite polarity and a write strobe are all active. An optional bit reversal fixes byte images whose bit order is opposite to the bus wiring.

When the local image is complete, a done flag goes high. In serial mode, every later bit on the data pin is then copied to a registered daisy-chain output, so devices further down the chain receive the rest of the stream. An active-low program input clears the block. The mode is taken from a static select pin while program is low.

Top module: `cfg_stream_loader`

## Requirements
- R1: In serial mode, one bit of `serIn` is stored on each rising edge of `cfgClk`. The first bit received ends up in the most significant bit of `cfgWord`, and later bits follow towards bit 0, so each byte arrives MSB first.
- R2: In parallel mode, a byte on `parData` is stored only on an edge where `csLowN`=0, `csHigh`=1 and `wrN`=0. On any other edge `cfgWord` does not change. The first byte accepted ends up in the top byte of `cfgWord`.
- R3: In serial mode, once `done` is high, `dout` shows the value of `serIn` from the previous rising edge.
- R4: In parallel mode, `dout` stays at 1 the whole time.
- R5: `done` goes high right after the edge that stores the last unit. That is bit number CFG_BYTES*8 in serial mode, or byte number CFG_BYTES in parallel mode. Before that edge `done` is 0. It stays at 1 until `progN` is driven low.
- R6: On an edge where `progN`=0, `cfgWord` is cleared, `done` is cleared, the unit count is cleared and `dout` is set to 1.
- R7: When `done` is high, further bits or bytes do not change `cfgWord`.
- R8: With `mirrorEn`=1, each parallel byte is stored with its bit order reversed (bus bit 7 goes to bit 0, and so on). `mirrorEn` has no effect in serial mode.
- R9: The value of `parMode` (1 = parallel, 0 = serial) at the last edge with `progN`=0 sets the mode for the whole load. Changes to `parMode` after that are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| cfgClk | input | 1 | External configuration clock; all state changes on its rising edge |
| progN | input | 1 | Active-low program; clears the block and captures the mode |
| parMode | input | 1 | Mode select: 1 = byte-wide, 0 = bit-serial |
| mirrorEn | input | 1 | Reverses the bit order of each parallel byte |
| serIn | input | 1 | Serial data input |
| parData | input | 8 | Parallel data bus |
| csLowN | input | 1 | Active-low chip select |
| csHigh | input | 1 | Active-high chip select |
| wrN | input | 1 | Active-low write strobe |
| dout | output | 1 | Registered daisy-chain output |
| done | output | 1 | Image complete |
| cfgWord | output | CFG_BYTES*8 | Stored configuration image |

## Verification
The assertions assume that `progN` is held low for at least one rising edge before any load. They also assume that all inputs are stable around each rising edge, because the block has no synchronizer of its own. The stimulus changes every input one nanosecond after a rising edge and holds `progN` low for several clocks before each load. Inside those limits, the chip selects, the write strobe and the data are random, and `parMode` and `mirrorEn` are changed on purpose in the middle of a load.

// File: rtl/cfgld_pkg.sv
package cfgld_pkg;
  // Strobes passed from control to datapath on each edge
  typedef struct packed {
    logic takeBit;   // shift one serial bit into the image
    logic takeByte;  // shift one parallel byte into the image
    logic forward;   // copy serial input to the chain output
  } cfgStrobe_t;
endpackage

// File: rtl/cfgld_ctrl.sv
module cfgld_ctrl
  import cfgld_pkg::*;
#(
  parameter int CFG_BYTES = 4
) (
  input  logic       cfgClk,
  input  logic       progN,
  input  logic       parMode,
  input  logic       csLowN,
  input  logic       csHigh,
  input  logic       wrN,
  output cfgStrobe_t stb,
  output logic       done,
  output logic       parSel
);
  localparam int WBITS = CFG_BYTES * 8;
  localparam int CW    = $clog2(WBITS + 1);

  logic [CW-1:0] unitCnt;
  logic [CW-1:0] lastUnit;
  logic          byteOk;

  assign lastUnit = parSel ? CW'(CFG_BYTES - 1) : CW'(WBITS - 1);
  assign byteOk   = !csLowN && csHigh && !wrN;

  always_comb begin
    stb.takeBit  = !done && !parSel;
    stb.takeByte = !done && parSel && byteOk;
    stb.forward  = done && !parSel;
  end

  always_ff @(posedge cfgClk) begin
    if (!progN) begin
      parSel  <= parMode;
      unitCnt <= '0;
      done    <= 1'b0;
    end else if (stb.takeBit || stb.takeByte) begin
      unitCnt <= unitCnt + 1'b1;
      if (unitCnt == lastUnit) done <= 1'b1;
    end
  end
endmodule

// File: rtl/cfgld_datapath.sv
module cfgld_datapath
  import cfgld_pkg::*;
#(
  parameter int CFG_BYTES = 4
) (
  input  logic                   cfgClk,
  input  logic                   progN,
  input  logic                   mirrorEn,
  input  logic                   serIn,
  input  logic [7:0]             parData,
  input  cfgStrobe_t             stb,
  output logic [CFG_BYTES*8-1:0] cfgWord,
  output logic                   dout
);
  localparam int WBITS = CFG_BYTES * 8;

  logic [7:0] flipped;
  logic [7:0] byteIn;

  for (genvar i = 0; i < 8; i++) begin : g_flip
    assign flipped[i] = parData[7-i];
  end

  assign byteIn = mirrorEn ? flipped : parData;

  always_ff @(posedge cfgClk) begin
    if (!progN) begin
      cfgWord <= '0;
      dout    <= 1'b1;
    end else begin
      if (stb.takeBit)
        cfgWord <= (cfgWord << 1) | WBITS'(serIn);
      else if (stb.takeByte)
        cfgWord <= (cfgWord << 8) | WBITS'(byteIn);
      dout <= stb.forward ? serIn : 1'b1;
    end
  end
endmodule

// File: rtl/cfg_stream_loader.sv
module cfg_stream_loader
  import cfgld_pkg::*;
#(
  parameter int CFG_BYTES = 4
) (
  input  logic                   cfgClk,
  input  logic                   progN,
  input  logic                   parMode,
  input  logic                   mirrorEn,
  input  logic                   serIn,
  input  logic [7:0]             parData,
  input  logic                   csLowN,
  input  logic                   csHigh,
  input  logic                   wrN,
  output logic                   dout,
  output logic                   done,
  output logic [CFG_BYTES*8-1:0] cfgWord
);
  cfgStrobe_t stb;
  logic       parSel;

  cfgld_ctrl #(.CFG_BYTES(CFG_BYTES)) u_ctrl (
    .cfgClk (cfgClk),
    .progN  (progN),
    .parMode(parMode),
    .csLowN (csLowN),
    .csHigh (csHigh),
    .wrN    (wrN),
    .stb    (stb),
    .done   (done),
    .parSel (parSel)
  );

  cfgld_datapath #(.CFG_BYTES(CFG_BYTES)) u_dp (
    .cfgClk  (cfgClk),
    .progN   (progN),
    .mirrorEn(mirrorEn),
    .serIn   (serIn),
    .parData (parData),
    .stb     (stb),
    .cfgWord (cfgWord),
    .dout    (dout)
  );
endmodule

// File: rtl/cfgld_checker.sv
module cfgld_checker #(
  parameter int CFG_BYTES = 4
) (
  input logic                   cfgClk,
  input logic                   progN,
  input logic                   serIn,
  input logic                   csLowN,
  input logic                   csHigh,
  input logic                   wrN,
  input logic                   parSel,
  input logic                   dout,
  input logic                   done,
  input logic [CFG_BYTES*8-1:0] cfgWord
);
  // R6: program clears the outputs on the following edge
  assert_prog_clears_R6: assert property (@(posedge cfgClk)
    !progN |=> (!done && dout && cfgWord == '0));

  // R5: done is sticky until program
  assert_done_sticky_R5: assert property (@(posedge cfgClk) disable iff (!progN)
    done |=> done);

  // R7: image frozen once complete
  assert_frozen_R7: assert property (@(posedge cfgClk) disable iff (!progN)
    done |=> $stable(cfgWord));

  // R3: serial forwarding with one clock of delay
  assert_forward_R3: assert property (@(posedge cfgClk) disable iff (!progN)
    (done && !parSel) |=> (dout == $past(serIn)));

  // R4: chain output idle high in parallel mode
  assert_par_dout_high_R4: assert property (@(posedge cfgClk) disable iff (!progN)
    parSel |-> dout);

  // R2: unqualified parallel edges leave the image untouched
  assert_gap_ignored_R2: assert property (@(posedge cfgClk) disable iff (!progN)
    (parSel && (csLowN || !csHigh || wrN)) |=> $stable(cfgWord));
endmodule

bind cfg_stream_loader cfgld_checker #(.CFG_BYTES(CFG_BYTES)) u_chk (
  .cfgClk (cfgClk),
  .progN  (progN),
  .serIn  (serIn),
  .csLowN (csLowN),
  .csHigh (csHigh),
  .wrN    (wrN),
  .parSel (parSel),
  .dout   (dout),
  .done   (done),
  .cfgWord(cfgWord)
);

// File: tb/cfg_stream_loader_tb.sv
`timescale 1ns/1ps
module cfg_stream_loader_tb;
  localparam int CFG_BYTES = 4;
  localparam int WBITS = CFG_BYTES * 8;

  logic             cfgClk = 1'b0;
  logic             progN, parMode, mirrorEn, serIn, csLowN, csHigh, wrN;
  logic [7:0]       parData;
  logic             dout, done;
  logic [WBITS-1:0] cfgWord;
  logic [WBITS-1:0] expWord;
  int               total = 0;
  int               bad = 0;

  always #10 cfgClk = ~cfgClk;

  cfg_stream_loader #(.CFG_BYTES(CFG_BYTES)) u_dut (
    .cfgClk(cfgClk), .progN(progN), .parMode(parMode), .mirrorEn(mirrorEn),
    .serIn(serIn), .parData(parData), .csLowN(csLowN), .csHigh(csHigh),
    .wrN(wrN), .dout(dout), .done(done), .cfgWord(cfgWord)
  );

  function automatic logic [7:0] revByte(input logic [7:0] b);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = b[7-i];
    return r;
  endfunction

  task automatic tick();
    @(posedge cfgClk);
    #1;
  endtask

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic doProgram(input logic mode);
    progN = 1'b0; parMode = mode;
    repeat (3) tick();
    chk("R6 done cleared", 64'(done), 64'd0);
    chk("R6 dout high", 64'(dout), 64'd1);
    chk("R6 image cleared", 64'(cfgWord), 64'd0);
    progN = 1'b1;
  endtask

  initial begin
    #(20 * 150000);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_C0DE));
    progN = 1'b0; parMode = 1'b0; mirrorEn = 1'b0; serIn = 1'b0;
    parData = 8'h00; csLowN = 1'b1; csHigh = 1'b0; wrN = 1'b1;

    // serial load, mirror set (R8 ignored) and mode pin flipped (R9)
    for (int run = 0; run < 3; run++) begin
      doProgram(1'b0);
      parMode = 1'b1;
      mirrorEn = 1'b1;
      expWord = '0;
      for (int i = 0; i < WBITS; i++) begin
        logic b;
        b = (run == 0) ? 1'b1 : 1'($urandom);
        serIn = b;
        expWord = {expWord[WBITS-2:0], b};
        tick();
        if (i < WBITS - 1) chk("R5 no early done serial", 64'(done), 64'd0);
        else chk("R5 done after last bit", 64'(done), 64'd1);
      end
      chk("R1 R8 R9 serial image", 64'(cfgWord), 64'(expWord));
      for (int i = 0; i < 40; i++) begin
        logic b;
        b = 1'($urandom);
        serIn = b;
        tick();
        chk("R3 forwarded bit", 64'(dout), 64'(b));
      end
      chk("R7 image frozen serial", 64'(cfgWord), 64'(expWord));
      chk("R5 done held", 64'(done), 64'd1);
    end

    // parallel loads with random qualifier gaps
    for (int run = 0; run < 6; run++) begin
      int got;
      logic m;
      m = run[0];
      mirrorEn = m;
      doProgram(1'b1);
      parMode = 1'b0;
      expWord = '0;
      got = 0;
      while (got < CFG_BYTES) begin
        logic [7:0] d;
        int sel;
        d = 8'($urandom);
        sel = $urandom % 4;
        parData = d; serIn = 1'($urandom);
        csLowN = (sel == 1); csHigh = (sel != 2); wrN = (sel == 3);
        tick();
        if (sel == 0) begin
          expWord = {expWord[WBITS-9:0], m ? revByte(d) : d};
          got++;
        end else begin
          chk("R2 unqualified edge ignored", 64'(cfgWord), 64'(expWord));
        end
        chk("R4 dout high parallel", 64'(dout), 64'd1);
        if (got < CFG_BYTES) chk("R5 no early done parallel", 64'(done), 64'd0);
      end
      chk("R5 done after last byte", 64'(done), 64'd1);
      chk("R2 R8 R9 parallel image", 64'(cfgWord), 64'(expWord));
      for (int i = 0; i < 3; i++) begin
        parData = 8'($urandom); csLowN = 1'b0; csHigh = 1'b1; wrN = 1'b0;
        tick();
        chk("R7 byte after done ignored", 64'(cfgWord), 64'(expWord));
        chk("R4 dout high after done", 64'(dout), 64'd1);
      end
      csLowN = 1'b1; csHigh = 1'b0; wrN = 1'b1;
    end

    // directed: known byte with and without reversal
    for (int run = 0; run < 2; run++) begin
      logic m;
      m = run[0];
      mirrorEn = m;
      doProgram(1'b1);
      for (int i = 0; i < CFG_BYTES; i++) begin
        parData = 8'h01 << i; csLowN = 1'b0; csHigh = 1'b1; wrN = 1'b0;
        tick();
      end
      expWord = '0;
      for (int i = 0; i < CFG_BYTES; i++)
        expWord = {expWord[WBITS-9:0], m ? revByte(8'h01 << i) : (8'h01 << i)};
      chk("R8 directed mirror", 64'(cfgWord), 64'(expWord));
      csLowN = 1'b1; csHigh = 1'b0; wrN = 1'b1;
    end

    progN = 1'b0;
    tick();
    chk("R6 final clear done", 64'(done), 64'd0);
    chk("R6 final clear image", 64'(cfgWord), 64'd0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule